// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block is the host-side configuration access unit of a PCI host bridge. Software first writes a 32-bit index value into the index window. It then reads or writes the data window. Each data-window access becomes one configuration request on a downstream port. The request carries a bus/device/function/register address built from the latched index and the low bits of the data-window offset, along with the byte enables, the write flag and the write data. The host side is stalled until the downstream port acknowledges. A read returns the data that arrives with the acknowledge.

The index is decoded in one of three formats. Bit 31 set selects a raw format that passes the index through almost unchanged. Bit 0 set selects a type-1 style format in which the low three bits come from the offset. With both bits clear, the index is type-0 style: the device is given as a one-hot select bit in bits 31:11, and it is converted to a device number by finding the lowest set bit. The block also combines per-device interrupt pins onto four shared level-sensitive interrupt lines. Each pin is routed by a rotation based on the device number.

The host address is 13 bits wide. Bit 12 selects the window: 0 is the index window and 1 is the data window. Each window covers a 4 KiB range, and both windows use little-endian byte lanes: byte enable bit n covers data bits 8n+7:8n.

Top module: `cfg_xlate_top`

## Requirements
- R1: The index register resets to zero. A host write to the index window updates only the bytes whose enable bit is set. A host read of the index window returns the current index value.
- R2: An index-window access completes in the same cycle it is presented (`hready_o` high) and raises no downstream request.
- R3: When index bit 31 is set, the forwarded address is the index value with data-window offset bits [1:0] ORed into its bits [1:0].
- R4: When index bit 31 is clear and bit 0 is set, the forwarded address is the index with bits [2:0] replaced by data-window offset bits [2:0].
- R5: When index bits 31 and 0 are both clear, the forwarded address is built as follows. Bits 31:16 are zero. Bits 15:11 hold the position of the lowest set bit among index bits 31:11. Bits 10:8 are index bits 10:8. Bits 7:3 are index bits 7:3. Bits 2:0 are offset bits [2:0].
- R6: In the type-0 style format, if index bits 31:11 are all zero, the device field (bits 15:11) is 31.
- R7: A data-window access raises exactly one downstream request. Its address, byte enables, write flag and write data stay stable until acknowledged, and the host sees no completion before that acknowledge.
- R8: A data-window write forwards the host write data and byte enables unchanged. A data-window read returns the downstream read data in the acknowledge cycle.
- R9: Interrupt pin p (0..3) of device d drives shared line (p + d) mod 4. In the pin input, pin p of device d is bit 4d+p.
- R10: A shared interrupt line is the OR of all pins that map to it, and it is low when none of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hreq_i | input | 1 | Host access request, held until hready_o |
| hwe_i | input | 1 | Host write (1) or read (0) |
| haddr_i | input | 13 | Host address; bit 12 selects the data window |
| hbe_i | input | 4 | Host byte enables |
| hwdata_i | input | 32 | Host write data |
| hrdata_o | output | 32 | Host read data, valid with hready_o |
| hready_o | output | 1 | Host access completes this cycle |
| cfg_req_o | output | 1 | Downstream configuration request |
| cfg_addr_o | output | 32 | Translated configuration address |
| cfg_be_o | output | 4 | Downstream byte enables |
| cfg_we_o | output | 1 | Downstream write flag |
| cfg_wdata_o | output | 32 | Downstream write data |
| cfg_ack_i | input | 1 | Downstream acknowledge |
| cfg_rdata_i | input | 32 | Downstream read data, valid with cfg_ack_i |
| dev_irq_i | input | 128 | Device interrupt pin levels, 4 per device |
| irq_o | output | 4 | Shared interrupt lines |

## Verification
Some properties are checked on every cycle by assertions. A pending downstream request must hold steady until acknowledged. An acknowledge must end the request. The index register must not change without an index write. An index access must never complete while a downstream request is in flight. All interrupt lines must be quiet when every pin is low. Other behaviour can only be shown by the bench's scenarios. These are the three address formats, including the lowest-set-bit search and the empty device-select case; byte-lane merging into the index; the round trip of read data; and the rotation and OR-ing of the interrupt pins. The bench checks every downstream request against a queue of expected requests.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned BEW = DW / 8;
  localparam int unsigned NUM_LINES = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } acc_state_e;

  typedef struct packed {
    logic [DW-1:0]  addr;
    logic [BEW-1:0] be;
    logic           we;
    logic [DW-1:0]  wdata;
  } cfg_cmd_t;
endpackage

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
  import cfg_xlate_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [BEW-1:0] be_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  idx_o
);
  logic [DW-1:0] idx_q;

  for (genvar b = 0; b < BEW; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               idx_q[8*b +: 8] <= '0;
      else if (wr_i && be_i[b])  idx_q[8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign idx_o = idx_q;

  a_r1_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(idx_o));
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
(
  input  logic [DW-1:0] idx_i,
  input  logic [2:0]    off_i,
  output logic [DW-1:0] addr_o
);
  localparam int unsigned SEL_LO = 11;

  logic [4:0] dev_num;

  // lowest set select bit wins; none set gives all ones
  always_comb begin
    dev_num = '1;
    for (int k = DW - 1; k >= SEL_LO; k--) begin
      if (idx_i[k]) dev_num = 5'(k);
    end
  end

  always_comb begin
    if (idx_i[DW-1]) begin
      addr_o = idx_i | {{(DW-2){1'b0}}, off_i[1:0]};
    end else if (idx_i[0]) begin
      addr_o = {idx_i[DW-1:3], off_i};
    end else begin
      addr_o = {16'h0, dev_num, idx_i[10:8], idx_i[7:3], off_i};
    end
  end
endmodule

// File: rtl/cfg_data_fsm.sv
module cfg_data_fsm
  import cfg_xlate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  cfg_cmd_t      cmd_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          cfg_req_o,
  output cfg_cmd_t      cmd_o,
  input  logic          cfg_ack_i
);
  acc_state_e state_q;
  cfg_cmd_t   cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_BUSY;
          cmd_q   <= cmd_i;
        end
        ST_BUSY: if (cfg_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign cfg_req_o = (state_q == ST_BUSY);
  assign done_o    = cfg_req_o && cfg_ack_i;
  assign cmd_o     = cmd_q;

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cmd_o));
  a_r7_ack_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i |=> !cfg_req_o);
endmodule

// File: rtl/cfg_irq_route.sv
module cfg_irq_route
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned NUM_DEV = 32
) (
  input  logic [4*NUM_DEV-1:0]   pin_i,
  output logic [NUM_LINES-1:0]   line_o
);
  always_comb begin
    line_o = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < 4; p++) begin
        line_o[(p + d) % NUM_LINES] = line_o[(p + d) % NUM_LINES] | pin_i[4*d + p];
      end
    end
  end
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned HADDR_W = 13,
  parameter int unsigned NUM_DEV = 32,
  localparam int unsigned WIN_BIT = HADDR_W - 1,
  localparam int unsigned PIN_W   = 4 * NUM_DEV
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hreq_i,
  input  logic               hwe_i,
  input  logic [HADDR_W-1:0] haddr_i,
  input  logic [3:0]         hbe_i,
  input  logic [31:0]        hwdata_i,
  output logic [31:0]        hrdata_o,
  output logic               hready_o,
  output logic               cfg_req_o,
  output logic [31:0]        cfg_addr_o,
  output logic [3:0]         cfg_be_o,
  output logic               cfg_we_o,
  output logic [31:0]        cfg_wdata_o,
  input  logic               cfg_ack_i,
  input  logic [31:0]        cfg_rdata_i,
  input  logic [PIN_W-1:0]   dev_irq_i,
  output logic [3:0]         irq_o
);
  logic          data_win;
  logic          idx_wr;
  logic [DW-1:0] idx;
  logic [DW-1:0] xl_addr;
  logic          fsm_idle;
  logic          fsm_done;
  cfg_cmd_t      cmd_in;
  cfg_cmd_t      cmd_out;

  assign data_win = haddr_i[WIN_BIT];
  assign idx_wr   = hreq_i && hwe_i && !data_win;

  cfg_index_reg i_idx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (idx_wr),
    .be_i    (hbe_i),
    .wdata_i (hwdata_i),
    .idx_o   (idx)
  );

  cfg_addr_xlate i_xlate (
    .idx_i  (idx),
    .off_i  (haddr_i[2:0]),
    .addr_o (xl_addr)
  );

  assign cmd_in = '{addr: xl_addr, be: hbe_i, we: hwe_i, wdata: hwdata_i};

  cfg_data_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (hreq_i && data_win),
    .cmd_i     (cmd_in),
    .idle_o    (fsm_idle),
    .done_o    (fsm_done),
    .cfg_req_o (cfg_req_o),
    .cmd_o     (cmd_out),
    .cfg_ack_i (cfg_ack_i)
  );

  assign cfg_addr_o  = cmd_out.addr;
  assign cfg_be_o    = cmd_out.be;
  assign cfg_we_o    = cmd_out.we;
  assign cfg_wdata_o = cmd_out.wdata;

  assign hready_o = data_win ? fsm_done : (hreq_i && fsm_idle);
  assign hrdata_o = data_win ? cfg_rdata_i : idx;

  cfg_irq_route #(.NUM_DEV(NUM_DEV)) i_irq (
    .pin_i  (dev_irq_i),
    .line_o (irq_o)
  );

  a_r2_idx_no_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_o && !data_win |-> !cfg_req_o);
  a_r7_done_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hready_o && data_win |-> cfg_ack_i && cfg_req_o);
  a_r10_lines_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_i == '0 |-> irq_o == '0);
endmodule

// File: tb/test_cfg_xlate_top.sv
module test_cfg_xlate_top;
  localparam int NDEV = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq = 1'b0, hwe = 1'b0;
  logic [12:0] haddr = '0;
  logic [3:0]  hbe = '0;
  logic [31:0] hwdata = '0, hrdata;
  logic        hready;
  logic        cfg_req, cfg_we;
  logic [31:0] cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic [4*NDEV-1:0] dev_irq = '0;
  logic [3:0]  irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] addr; logic [3:0] be; logic we; logic [31:0] wdata; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  cfg_xlate_top i_cfg_xlate_top (
    .clk_i(clk), .rst_ni(rst_n), .hreq_i(hreq), .hwe_i(hwe), .haddr_i(haddr),
    .hbe_i(hbe), .hwdata_i(hwdata), .hrdata_o(hrdata), .hready_o(hready),
    .cfg_req_o(cfg_req), .cfg_addr_o(cfg_addr), .cfg_be_o(cfg_be), .cfg_we_o(cfg_we),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata),
    .dev_irq_i(dev_irq), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_pattern(input logic [31:0] a);
    return a ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [31:0] model_addr(input logic [31:0] ix, input logic [2:0] off);
    logic [4:0] dev;
    if (ix[31]) return {ix[31:2], ix[1:0] | off[1:0]};
    if (ix[0])  return {ix[31:3], off};
    dev = 5'd31;
    for (int k = 11; k <= 31; k++) if (ix[k]) begin dev = 5'(k); break; end
    return {16'h0, dev, ix[10:8], ix[7:3], off};
  endfunction

  // downstream monitor + responder: compares each request against the queue
  int lat = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req && !cfg_ack) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected request", cfg_addr, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(cfg_addr == e.addr, "R3/R4/R5/R6 address", cfg_addr, e.addr);
          chk(cfg_we == e.we && cfg_be == e.be, "R8 we/be", {27'h0, cfg_we, cfg_be}, {27'h0, e.we, e.be});
          if (e.we) chk(cfg_wdata == e.wdata, "R8 write data", cfg_wdata, e.wdata);
        end
        repeat (lat) @(negedge clk);
        lat = (lat + 1) % 3;
        cfg_rdata = rd_pattern(cfg_addr);
        cfg_ack = 1'b1;
        @(negedge clk);
        cfg_ack = 1'b0;
      end
    end
  end

  task automatic host(input bit we, input logic [12:0] a, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output bit req_seen);
    @(negedge clk);
    hreq = 1'b1; hwe = we; haddr = a; hbe = be; hwdata = wd;
    req_seen = 0;
    forever begin
      #5;
      if (cfg_req) req_seen = 1;
      if (hready) begin rd = hrdata; break; end
      @(negedge clk);
    end
    @(negedge clk);
    hreq = 1'b0;
  endtask

  task automatic wr_idx(input logic [31:0] v, input logic [3:0] be);
    logic [31:0] rd; bit s;
    host(1, 13'h0000, be, v, rd, s);
  endtask

  task automatic data_acc(input bit we, input logic [11:0] off, input logic [31:0] ix,
                          input logic [31:0] wd, input logic [3:0] be, input string req);
    logic [31:0] rd; bit s; exp_t e;
    e.addr = model_addr(ix, off[2:0]); e.be = be; e.we = we; e.wdata = wd;
    exp_q.push_back(e);
    host(we, {1'b1, off}, be, wd, rd, s);
    chk(s, {req, " request raised"}, {31'h0, s}, 32'h1);
    if (!we) chk(rd == rd_pattern(e.addr), {req, " R8 read data"}, rd, rd_pattern(e.addr));
  endtask

  initial begin
    logic [31:0] rd; bit s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value, R2 same-cycle completion
    host(0, 13'h0004, 4'hF, 0, rd, s);
    chk(rd == 32'h0, "R1 reset index", rd, 32'h0);
    chk(!s, "R2 no request on index read", {31'h0, s}, 32'h0);
    #1 chk(irq == 4'h0, "R10 idle lines", {28'h0, irq}, 32'h0);

    wr_idx(32'h1234_5678, 4'hF);
    host(0, 13'h0ffc, 4'hF, 0, rd, s);
    chk(rd == 32'h1234_5678, "R1 full write", rd, 32'h1234_5678);
    wr_idx(32'h00AA_0000, 4'b0100);
    host(0, 13'h0000, 4'hF, 0, rd, s);
    chk(rd == 32'h12AA_5678, "R1 byte-lane write", rd, 32'h12AA_5678);
    chk(!s, "R2 no request on index access", {31'h0, s}, 32'h0);

    // R3 raw format
    wr_idx(32'h8001_2348, 4'hF);
    data_acc(0, 12'h007, 32'h8001_2348, 0, 4'hF, "R3");
    wr_idx(32'h8000_0801, 4'hF);
    data_acc(1, 12'h002, 32'h8000_0801, 32'hDEAD_BEEF, 4'b1100, "R3");
    // R4 type-1 style
    wr_idx(32'h0005_A8FF, 4'hF);
    data_acc(0, 12'h005, 32'h0005_A8FF, 0, 4'hF, "R4");
    data_acc(1, 12'h000, 32'h0005_A8FF, 32'h0102_0304, 4'b0001, "R4");
    // R5 type-0 style, lowest set bit wins
    wr_idx(32'h0001_0340, 4'hF);
    data_acc(0, 12'h003, 32'h0001_0340, 0, 4'hF, "R5");
    wr_idx(32'h4000_4D0C, 4'hF);
    data_acc(1, 12'h006, 32'h4000_4D0C, 32'hCAFE_F00D, 4'b0011, "R5");
    wr_idx(32'h0000_0800, 4'hF);
    data_acc(0, 12'h000, 32'h0000_0800, 0, 4'hF, "R5");
    // R6 no select bit -> device 31
    wr_idx(32'h0000_07F8, 4'hF);
    data_acc(0, 12'h004, 32'h0000_07F8, 0, 4'hF, "R6");
    chk(model_addr(32'h0000_07F8, 3'h4) == 32'h0000_FFFC, "R6 model", model_addr(32'h0000_07F8, 3'h4), 32'h0000_FFFC);
    // R7 back-to-back accesses, each exactly one request
    data_acc(0, 12'hff1, 32'h0000_07F8, 0, 4'hF, "R7");
    data_acc(1, 12'h002, 32'h0000_07F8, 32'h5555_AAAA, 4'hF, "R7");
    @(negedge clk); @(negedge clk);
    chk(exp_q.size() == 0, "R7 all requests seen", exp_q.size(), 0);
    chk(!cfg_req, "R7 request dropped", {31'h0, cfg_req}, 0);

    // R9 rotation, R10 OR
    dev_irq = '0; dev_irq[4*5 + 2] = 1'b1;        // (2+5)%4 = 3
    #1 chk(irq == 4'b1000, "R9 dev5 pin2", {28'h0, irq}, 32'h8);
    dev_irq = '0; dev_irq[4*13 + 3] = 1'b1;       // (3+13)%4 = 0
    #1 chk(irq == 4'b0001, "R9 dev13 pin3", {28'h0, irq}, 32'h1);
    dev_irq = '0; dev_irq[4*0 + 1] = 1'b1;        // line 1
    #1 chk(irq == 4'b0010, "R9 dev0 pin1", {28'h0, irq}, 32'h2);
    dev_irq = '0; dev_irq[4*1 + 1] = 1'b1; dev_irq[4*2 + 0] = 1'b1; // both line 2
    #1 chk(irq == 4'b0100, "R10 shared line", {28'h0, irq}, 32'h4);
    dev_irq[4*1 + 1] = 1'b0;
    #1 chk(irq == 4'b0100, "R10 one source left", {28'h0, irq}, 32'h4);
    dev_irq[4*31 + 3] = 1'b1;                     // (3+31)%4 = 2, plus line
    dev_irq[4*31 + 0] = 1'b1;                     // (0+31)%4 = 3
    #1 chk(irq == 4'b1100, "R10 mixed", {28'h0, irq}, 32'hC);
    dev_irq = '0;
    #1 chk(irq == 4'b0000, "R10 all low", {28'h0, irq}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule